// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block is a single-level cache between a processor request port and a main-memory port. Addresses are 16 bits wide. The cache holds 128 lines, and each line holds four 32-bit words. Each line is chosen by the block address modulo 128, so only one stored tag is compared on each access.

Reads that hit return their word in the cycle they are presented. A read miss stalls the processor while the whole line is fetched from memory and installed, and the requested word is then returned from the fresh line. Every write goes straight to memory with its byte enables, and the processor waits for memory to accept it because there is no write buffer. A write that hits also merges its enabled bytes into the cached line. A write that misses leaves the cache untouched, so only read misses fill lines.

The memory side uses a request/ready handshake. For a line fetch, `mem_addr` is the line-aligned address and memory returns the four words on four `mem_ready` beats in ascending word order. For a write, memory gives one `mem_ready` beat once the write is done.

Top module: `dmc_cache_top`

## Requirements
- R1: Reset invalidates every line. After reset `cpu_stall`, `cpu_done` and `mem_req` are low, and the first read of any address is a miss.
- R2: The address splits into a tag in bits 15:11, a line index in bits 10:4, a word select in bits 3:2 and a byte lane in bits 1:0. Two addresses with the same index and different tags evict each other.
- R3: A read hit raises `cpu_done` with the correct `cpu_rdata` in the same cycle the request is presented, and makes no memory request.
- R4: A read miss requests the line-aligned address (`mem_addr[3:0]` = 0, `mem_we` = 0) and accepts words 0 to 3 in order. With a memory that gives its first beat L cycles after the request, `cpu_done` rises L+5 cycles after the request cycle, and `cpu_rdata` holds the memory word.
- R5: After a fill, a read of any word of that line hits.
- R6: Every write raises `mem_req` with `mem_we` = 1 and passes `cpu_addr`, `cpu_wdata` and `cpu_be` (bit n enables bits 8n+7:8n) to memory. `cpu_done` rises in the cycle of the memory's `mem_ready`, L+1 cycles after the request cycle.
- R7: A write hit merges only the enabled byte lanes into the cached word. A following read hits and returns the merged word.
- R8: A write miss does not allocate a line. A later read of that address misses and returns the written data from memory.
- R9: `cpu_stall` is high in every cycle from the request cycle up to, but not including, the cycle in which `cpu_done` is high.
- R10: Refilling a line replaces the previous tag, so the earlier block misses again when it is read afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request valid; held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte-lane enables for writes |
| cpu_rdata | output | 32 | Read data, valid with cpu_done on reads |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Request pending, not complete |
| mem_req | output | 1 | Memory access active |
| mem_we | output | 1 | 1 = memory write, 0 = line fetch |
| mem_addr | output | 16 | Line-aligned fetch address or write address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte enables |
| mem_ready | input | 1 | Fetch beat or write completion |
| mem_rdata | input | 32 | Fetched word, valid with mem_ready |

## Verification
The first stimulus is a directed sequence: a cold miss, then hits on the other words of the same line, then partial-byte write hits and a write miss. These separate a correct tag and valid lookup from one that refills too often or allocates on writes. A pair of conflicting addresses on the same index, and accesses at the top index and the top tag, test the field split and the replacement. A long pseudo-random mix over a small address window with many aliasing tags then checks latency, data and stall against a behavioural model. That model keeps a valid/tag table and a memory image, and it is compared on every cycle of every access.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  parameter int ADDR_W = 16;
  parameter int OFF_W  = 4;
  parameter int IDX_W  = 7;
  parameter int WORD_W = 32;

  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int BYTE_W = WORD_W / 8;
  localparam int LANE_W = $clog2(BYTE_W);
  localparam int WSEL_W = OFF_W - LANE_W;
  localparam int WPB    = 1 << WSEL_W;
  localparam int LINES  = 1 << IDX_W;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_WRITE, ST_RESP} dmc_state_e;

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [WSEL_W-1:0] addr_word(input logic [ADDR_W-1:0] a);
    return a[LANE_W +: WSEL_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store
  import dmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
  import dmc_pkg::*;
(
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [BYTE_W-1:0] wr_be,
  input  logic [WORD_W-1:0] wr_data
);
  localparam int DEPTH = LINES * WPB;
  logic [WORD_W-1:0] store_q [DEPTH];

  assign rd_data = store_q[{rd_idx, rd_word}];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BYTE_W; b++) begin
        if (wr_be[b]) store_q[{wr_idx, wr_word}][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              hit,
  input  logic              mem_ready,
  output dmc_state_e        state,
  output logic [WSEL_W-1:0] beat,
  output logic              cpu_done,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic              fill_we,
  output logic              fill_last,
  output logic              line_wr_we
);
  dmc_state_e state_q, state_d;
  logic [WSEL_W-1:0] beat_q;
  logic idle_rd_hit;

  assign state       = state_q;
  assign beat        = beat_q;
  assign idle_rd_hit = (state_q == ST_IDLE) && cpu_req && !cpu_we && hit;
  assign mem_req     = (state_q == ST_FILL) || (state_q == ST_WRITE);
  assign mem_we      = (state_q == ST_WRITE);
  assign fill_we     = (state_q == ST_FILL) && mem_ready;
  assign fill_last   = fill_we && (&beat_q);
  assign line_wr_we  = (state_q == ST_WRITE) && mem_ready && hit;
  assign cpu_done    = idle_rd_hit || ((state_q == ST_WRITE) && mem_ready) || (state_q == ST_RESP);
  assign cpu_stall   = (state_q == ST_FILL) || ((state_q == ST_WRITE) && !mem_ready) ||
                       ((state_q == ST_IDLE) && cpu_req && !idle_rd_hit);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cpu_req && cpu_we) state_d = ST_WRITE;
                else if (cpu_req && !hit) state_d = ST_FILL;
      ST_FILL:  if (fill_last) state_d = ST_RESP;
      ST_WRITE: if (mem_ready) state_d = ST_IDLE;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (fill_we) beat_q <= beat_q + 1'b1;
    end
  end

  // R9
  stall_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (cpu_stall || cpu_done));

  // R4
  resp_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESP) |-> ($past(mem_ready) && !mem_req));

  // R6
  write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && cpu_we) |-> (mem_ready && mem_we));
endmodule

// File: rtl/dmc_cache_top.sv
module dmc_cache_top
  import dmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  input  logic [BYTE_W-1:0] cpu_be,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [BYTE_W-1:0] mem_be,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata
);
  dmc_state_e        state;
  logic [WSEL_W-1:0] beat;
  logic              hit, fill_we, fill_last, line_wr_we;
  logic              dst_we;
  logic [WSEL_W-1:0] dst_word;
  logic [BYTE_W-1:0] dst_be;
  logic [WORD_W-1:0] dst_data;

  dmc_tag_store u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(addr_idx(cpu_addr)), .lk_tag(addr_tag(cpu_addr)), .lk_hit(hit),
    .wr_en(fill_last), .wr_idx(addr_idx(cpu_addr)), .wr_tag(addr_tag(cpu_addr))
  );

  assign dst_we   = fill_we || line_wr_we;
  assign dst_word = fill_we ? beat : addr_word(cpu_addr);
  assign dst_be   = fill_we ? {BYTE_W{1'b1}} : cpu_be;
  assign dst_data = fill_we ? mem_rdata : cpu_wdata;

  dmc_data_store u_data (
    .clk(clk),
    .rd_idx(addr_idx(cpu_addr)), .rd_word(addr_word(cpu_addr)), .rd_data(cpu_rdata),
    .wr_en(dst_we), .wr_idx(addr_idx(cpu_addr)), .wr_word(dst_word),
    .wr_be(dst_be), .wr_data(dst_data)
  );

  dmc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .hit(hit),
    .mem_ready(mem_ready), .state(state), .beat(beat), .cpu_done(cpu_done),
    .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we), .fill_we(fill_we),
    .fill_last(fill_last), .line_wr_we(line_wr_we)
  );

  assign mem_addr  = (state == ST_FILL) ? line_base(cpu_addr) : cpu_addr;
  assign mem_wdata = cpu_wdata;
  assign mem_be    = (state == ST_WRITE) ? cpu_be : '0;

  // R3
  hit_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && cpu_req && !cpu_we && hit) |-> (cpu_done && !mem_req));

  // R8
  no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |-> (!cpu_we && (state == ST_FILL)));

  // R4
  fill_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[OFF_W-1:0] == '0));
endmodule

// File: tb/dmc_cache_top_tb.sv
module dmc_cache_top_tb;
  localparam int LAT = 3;
  localparam int MWORDS = 16384;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_rdata;
  logic cpu_done, cpu_stall, mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  dmc_cache_top u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
    .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  logic [31:0] bmem [MWORDS];
  logic [31:0] rmem [MWORDS];
  bit          mv [128];
  int          mt [128];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int mcnt = 0, mbeat = 0;
  logic [15:0] exp_maddr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  // behavioural memory: first beat LAT cycles after request seen
  always @(negedge clk) begin
    if (!rst_n || !mem_req) begin
      mem_ready = 1'b0; mcnt = 0; mbeat = 0;
    end else if (mcnt < LAT) begin
      mcnt++; mem_ready = 1'b0;
    end else if (mem_we) begin
      mem_ready = 1'b1;
      chk(mem_addr == exp_maddr, "R6", "write address", {16'h0, mem_addr}, {16'h0, exp_maddr});
      bmem[mem_addr[15:2]] = merge(bmem[mem_addr[15:2]], mem_wdata, mem_be);
    end else begin
      mem_ready = 1'b1;
      if (mbeat == 0)
        chk(mem_addr == {exp_maddr[15:4], 4'h0}, "R4", "fetch address",
            {16'h0, mem_addr}, {16'h0, exp_maddr[15:4], 4'h0});
      mem_rdata = bmem[{mem_addr[15:4], 2'(mbeat)}];
      mbeat++;
    end
  end

  task automatic access(input bit we, input logic [15:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input string dreq);
    int idx = int'(a[10:4]);
    int tg  = int'(a[15:11]);
    bit hit = mv[idx] && (mt[idx] == tg);
    int exp_lat, cyc;
    string lreq;
    logic [31:0] exp_d;
    if (we) begin
      exp_lat = LAT + 1; lreq = "R6";
      rmem[a[15:2]] = merge(rmem[a[15:2]], wd, be);
    end else begin
      exp_lat = hit ? 0 : LAT + 5; lreq = hit ? "R3" : "R4";
      if (!hit) begin mv[idx] = 1; mt[idx] = tg; end
    end
    exp_d = rmem[a[15:2]];
    exp_maddr = a;
    @(posedge clk); #1;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    cyc = 0;
    forever begin
      @(negedge clk); #1;
      if (cpu_done) break;
      // R9 stall held while pending
      chk(cpu_stall === 1'b1, "R9", "stall while pending", {31'h0, cpu_stall}, 32'h1);
      cyc++;
      if (cyc > 500) break;
    end
    chk(cpu_stall === 1'b0, "R9", "stall at done", {31'h0, cpu_stall}, 32'h0);
    chk(cyc == exp_lat, lreq, "latency", cyc, exp_lat);
    if (!we) chk(cpu_rdata === exp_d, dreq, "read data", cpu_rdata, exp_d);
    @(posedge clk); #1;
    cpu_req = 0; cpu_we = 0;
  endtask

  initial begin
    for (int i = 0; i < MWORDS; i++) begin
      bmem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
      rmem[i] = bmem[i];
    end
    for (int i = 0; i < 128; i++) begin mv[i] = 0; mt[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(cpu_stall === 0, "R1", "stall after reset", {31'h0, cpu_stall}, 0);
    chk(cpu_done === 0, "R1", "done after reset", {31'h0, cpu_done}, 0);
    chk(mem_req === 0, "R1", "mem_req after reset", {31'h0, mem_req}, 0);

    access(0, 16'h0124, 0, 0, "R1");          // cold miss
    access(0, 16'h0120, 0, 0, "R5");          // same line hits
    access(0, 16'h012C, 0, 0, "R5");
    access(1, 16'h0128, 32'hA1B2C3D4, 4'b0110, "R6");  // write hit
    access(0, 16'h0128, 0, 0, "R7");          // merged word hit
    access(1, 16'h3000, 32'hCAFEF00D, 4'hF, "R6");     // write miss
    access(0, 16'h3000, 0, 0, "R8");          // must miss
    access(0, 16'h0924, 0, 0, "R2");          // same index, other tag
    access(0, 16'h0124, 0, 0, "R10");         // evicted, misses again
    access(0, 16'h07F0, 0, 0, "R2");          // top index
    access(0, 16'h07F8, 0, 0, "R5");
    access(0, 16'hFFFC, 0, 0, "R2");          // top tag, top index
    access(1, 16'hFFFD, 32'h00EE0000, 4'b0100, "R7");
    access(0, 16'hFFFC, 0, 0, "R7");

    begin
      int seed = 32'h1234;
      for (int k = 0; k < 300; k++) begin
        logic [15:0] a;
        bit w;
        seed = seed * 1103515245 + 12345;
        a = {seed[20:19], 3'b000, seed[18:17], 3'b000, seed[16:15], 4'h0};
        a[3:2] = seed[14:13];
        w = (seed[24:22] < 3);
        access(w, a, seed ^ 32'h0F0F1234, seed[28:25] | 4'h1, w ? "R7" : "R5");
      end
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule